// File: doc/BRIEF.md
# Inter-Core Message Interrupt Controller

This block lets any one of up to four processor cores send a short message interrupt to another core. Each core owns an 8-byte window that holds two 32-bit registers: a control register that the core writes to send or acknowledge, and a status register that shows the last message delivered to it. The block drives one interrupt line per core. That line is high while the core's pending flag is set.

To send, a core writes its own control register with the generate bit set, a destination core index and a 16-bit payload. One cycle later the destination's status holds the pending flag, the sender's index and the payload, and the destination's interrupt line is high. The receiving core reads its status, then writes its own control register with the acknowledge bit set. This clears the pending flag and drops its line. The payload and sender stay readable after the acknowledge. Only one message is held per core: a second message overwrites the first.

The bus is a single-cycle register port. A write is accepted on the clock edge at which `req_i` and `we_i` are both high. Read data is combinational and reflects the current address. The core count is set by the parameter `NUM_CORES`, from 1 to 4. The address is `ADDR_W` bits wide, which is 6 by default and decodes eight slots.

Top module: `ipi_ctrl`

## Requirements
- R1: After reset, every control and status register reads 0 and every bit of `irq_o` is low.
- R2: A write to a core's control register (address bit 2 = 0, core index = address bits 3 and up) stores the full 32-bit word. A later read of that register returns the word unchanged.
- R3: A control write with bit 30 set and destination index bits 29:16 below `NUM_CORES` updates the destination's status on the next clock edge. The new status is bit 30 = 1, bits 29:16 = the writing core's index, bits 15:0 = the write's bits 15:0, and all other bits 0. The destination's `irq_o` bit goes high on the same edge.
- R4: A control write with bit 31 set clears bit 30 of the writing core's status and drops its `irq_o` bit. Bits 29:0 of that status are unchanged.
- R5: Within one control write, generate is applied before acknowledge. A core that targets itself with both bits set ends with its status holding the new sender and payload, pending 0, and its `irq_o` bit low.
- R6: Writes to a status register (address bit 2 = 1) change no register and no interrupt line.
- R7: A message sent to a core whose pending flag is already set replaces the previous sender and payload, and the pending flag stays set.
- R8: A generate request whose destination index is `NUM_CORES` or higher changes no status register and no interrupt line.
- R9: Accesses to a core slot at or above `NUM_CORES` read as 0. Writes to such a slot change no register and no interrupt line.
- R10: A control write with neither bit 30 nor bit 31 set changes no status register and no interrupt line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Bus access request |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W | Byte address: bit 2 selects the register, bits 3 and up select the core |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational, 0 when idle or when the slot is out of range |
| irq_o | output | NUM_CORES | Interrupt line per core, high while that core's message is pending |

## Verification
The hardest case to reach is a single write that both delivers to and acknowledges the same core. The bench reaches it by having core 1 write a control word that sets both request bits and names itself as destination. It then checks that the fresh sender and payload landed while the line stayed low. A second hard case is a message that overwrites one still pending. The bench reaches it by sending from core 3 to core 2, then from core 1 to core 2 with no acknowledge in between. It then confirms the second sender's fields replaced the first while the line held high. Out-of-range traffic is also driven: destinations 4 and 0x3FFF, and a generate written into slot 4's window. The bench checks that none of these disturbs any line or any status.

// File: rtl/ipi_pkg.sv
package ipi_pkg;
  localparam int DATA_W   = 32;
  localparam int ACK_BIT  = 31;
  localparam int GEN_BIT  = 30;
  localparam int PEND_BIT = 30;
  localparam int IDX_LSB  = 16;
  localparam int IDX_W    = 14;
  localparam int PAY_W    = 16;

  typedef struct packed {
    logic             pend;
    logic [IDX_W-1:0] sender;
    logic [PAY_W-1:0] payload;
  } msg_t;

  function automatic logic [DATA_W-1:0] pack_status(msg_t m);
    return {1'b0, m.pend, m.sender, m.payload};
  endfunction
endpackage

// File: rtl/ipi_addr_decode.sv
module ipi_addr_decode
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 6,
  localparam int SLOT_W   = ADDR_W - 3
) (
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [DATA_W-1:0]    wdata_i,
  output logic [SLOT_W-1:0]    slot_o,
  output logic                 is_status_o,
  output logic                 slot_ok_o,
  output logic [NUM_CORES-1:0] ctrl_wr_o,
  output logic [NUM_CORES-1:0] gen_hit_o,
  output logic [NUM_CORES-1:0] ack_o
);
  logic             any_ctrl_wr;
  logic [IDX_W-1:0] dst;

  assign slot_o      = addr_i[ADDR_W-1:3];
  assign is_status_o = addr_i[2];
  assign slot_ok_o   = slot_o < SLOT_W'(NUM_CORES);
  assign any_ctrl_wr = req_i && we_i && !is_status_o && slot_ok_o;
  assign dst         = wdata_i[IDX_LSB +: IDX_W];

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_dec
    assign ctrl_wr_o[k] = any_ctrl_wr && (slot_o == SLOT_W'(k));
    assign gen_hit_o[k] = any_ctrl_wr && wdata_i[GEN_BIT] && (dst == IDX_W'(k));
    assign ack_o[k]     = ctrl_wr_o[k] && wdata_i[ACK_BIT];
  end
endmodule

// File: rtl/ipi_core_slot.sv
module ipi_core_slot
  import ipi_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ctrl_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              gen_hit_i,
  input  logic [IDX_W-1:0]  sender_i,
  input  logic [PAY_W-1:0]  payload_i,
  input  logic              ack_i,
  output logic [DATA_W-1:0] ctrl_o,
  output logic [DATA_W-1:0] status_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] ctrl_q;
  msg_t              msg_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      msg_q  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i;
      if (gen_hit_i) msg_q <= '{pend: 1'b1, sender: sender_i, payload: payload_i};
      // acknowledge wins over a same-write self delivery
      if (ack_i) msg_q.pend <= 1'b0;
    end
  end

  assign ctrl_o   = ctrl_q;
  assign status_o = pack_status(msg_q);
  assign irq_o    = msg_q.pend;

  AST_GEN_SETS_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gen_hit_i && !ack_i |=> irq_o && status_o[PEND_BIT]); // R3
  AST_ACK_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i |=> !irq_o); // R4
  AST_ACK_KEEPS_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ack_i && !gen_hit_i |=> $stable(status_o[PEND_BIT-1:0])); // R4
  AST_STATUS_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !gen_hit_i && !ack_i |=> $stable(status_o) && $stable(irq_o)); // R6
  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_o)); // R2
endmodule

// File: rtl/ipi_rd_mux.sv
module ipi_rd_mux
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int SLOT_W    = 3
) (
  input  logic              rd_en_i,
  input  logic [SLOT_W-1:0] slot_i,
  input  logic              is_status_i,
  input  logic              slot_ok_i,
  input  logic [DATA_W-1:0] ctrl_i   [NUM_CORES],
  input  logic [DATA_W-1:0] status_i [NUM_CORES],
  output logic [DATA_W-1:0] rdata_o
);
  always_comb begin
    rdata_o = '0;
    if (rd_en_i && slot_ok_i) begin
      for (int k = 0; k < NUM_CORES; k++) begin
        if (slot_i == SLOT_W'(k)) rdata_o = is_status_i ? status_i[k] : ctrl_i[k];
      end
    end
  end
endmodule

// File: rtl/ipi_ctrl.sv
module ipi_ctrl
  import ipi_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 req_i,
  input  logic                 we_i,
  input  logic [ADDR_W-1:0]    addr_i,
  input  logic [31:0]          wdata_i,
  output logic [31:0]          rdata_o,
  output logic [NUM_CORES-1:0] irq_o
);
  localparam int SLOT_W = ADDR_W - 3;

  logic [SLOT_W-1:0]    slot;
  logic                 is_status;
  logic                 slot_ok;
  logic [NUM_CORES-1:0] ctrl_wr;
  logic [NUM_CORES-1:0] gen_hit;
  logic [NUM_CORES-1:0] ack;
  logic [IDX_W-1:0]     sender;
  logic [DATA_W-1:0]    ctrl_arr   [NUM_CORES];
  logic [DATA_W-1:0]    status_arr [NUM_CORES];

  ipi_addr_decode #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_dec (
    .req_i      (req_i),
    .we_i       (we_i),
    .addr_i     (addr_i),
    .wdata_i    (wdata_i),
    .slot_o     (slot),
    .is_status_o(is_status),
    .slot_ok_o  (slot_ok),
    .ctrl_wr_o  (ctrl_wr),
    .gen_hit_o  (gen_hit),
    .ack_o      (ack)
  );

  assign sender = {{(IDX_W-SLOT_W){1'b0}}, slot};

  for (genvar k = 0; k < NUM_CORES; k++) begin : g_slot
    ipi_core_slot u_slot (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .ctrl_we_i(ctrl_wr[k]),
      .wdata_i  (wdata_i),
      .gen_hit_i(gen_hit[k]),
      .sender_i (sender),
      .payload_i(wdata_i[PAY_W-1:0]),
      .ack_i    (ack[k]),
      .ctrl_o   (ctrl_arr[k]),
      .status_o (status_arr[k]),
      .irq_o    (irq_o[k])
    );
  end

  ipi_rd_mux #(.NUM_CORES(NUM_CORES), .SLOT_W(SLOT_W)) u_rd (
    .rd_en_i    (req_i),
    .slot_i     (slot),
    .is_status_i(is_status),
    .slot_ok_i  (slot_ok),
    .ctrl_i     (ctrl_arr),
    .status_i   (status_arr),
    .rdata_o    (rdata_o)
  );

  AST_ONE_TARGET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gen_hit)); // R3
  AST_BAD_DST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && wdata_i[GEN_BIT] && (wdata_i[29:16] >= IDX_W'(NUM_CORES))
    |-> gen_hit == '0); // R8
  AST_OOR_READ_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && (addr_i[ADDR_W-1:3] >= SLOT_W'(NUM_CORES)) |-> rdata_o == '0); // R9
  AST_OOR_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && (addr_i[ADDR_W-1:3] >= SLOT_W'(NUM_CORES)) |=> $stable(irq_o)); // R9
  AST_STATUS_WRITE_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i && we_i && addr_i[2] |=> $stable(irq_o)); // R6
endmodule

// File: tb/ipi_ctrl_bench.sv
module ipi_ctrl_bench;
  localparam int N  = 4;
  localparam int AW = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0;
  logic          we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [N-1:0]  irq;
  int            checks = 0;
  int            errors = 0;

  always #10 clk = ~clk;

  ipi_ctrl #(.NUM_CORES(N), .ADDR_W(AW)) u_ipi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic check(input string req_tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req_tag, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0; wdata = '0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  function automatic logic [AW-1:0] ctl(input int c);
    return AW'(c * 8);
  endfunction
  function automatic logic [AW-1:0] sts(input int c);
    return AW'(c * 8 + 4);
  endfunction

  task automatic t_reset();
    logic [31:0] d;
    check("R1 irq", 32'(irq), 32'h0);
    for (int c = 0; c < N; c++) begin
      rd(ctl(c), d); check("R1 ctrl", d, 32'h0);
      rd(sts(c), d); check("R1 status", d, 32'h0);
    end
  endtask

  task automatic t_plain_ctrl();
    logic [31:0] d;
    wr(ctl(1), 32'h0003_1234);
    rd(ctl(1), d); check("R2 readback", d, 32'h0003_1234);
    rd(sts(3), d); check("R10 no delivery", d, 32'h0);
    check("R10 irq", 32'(irq), 32'h0);
  endtask

  task automatic t_generate();
    logic [31:0] d;
    wr(ctl(3), 32'h4002_BEEF);
    check("R3 irq", 32'(irq), 32'h4);
    rd(sts(2), d); check("R3 status", d, 32'h4003_BEEF);
  endtask

  task automatic t_overwrite();
    logic [31:0] d;
    wr(ctl(1), 32'h4002_0042);
    check("R7 irq", 32'(irq), 32'h4);
    rd(sts(2), d); check("R7 status", d, 32'h4001_0042);
  endtask

  task automatic t_status_write();
    logic [31:0] d;
    wr(sts(2), 32'h0);
    wr(sts(0), 32'hFFFF_FFFF);
    check("R6 irq", 32'(irq), 32'h4);
    rd(sts(2), d); check("R6 status2", d, 32'h4001_0042);
    rd(sts(0), d); check("R6 status0", d, 32'h0);
  endtask

  task automatic t_ack();
    logic [31:0] d;
    wr(ctl(2), 32'h8000_0000);
    check("R4 irq", 32'(irq), 32'h0);
    rd(sts(2), d); check("R4 status", d, 32'h0001_0042);
    rd(ctl(2), d); check("R2 ack word", d, 32'h8000_0000);
  endtask

  task automatic t_self();
    logic [31:0] d;
    wr(ctl(1), 32'hC001_0077);
    check("R5 irq", 32'(irq), 32'h0);
    rd(sts(1), d); check("R5 status", d, 32'h0001_0077);
  endtask

  task automatic t_bad_dst();
    logic [31:0] d;
    wr(ctl(0), 32'h4004_0001);
    wr(ctl(0), 32'h7FFF_0002);
    check("R8 irq", 32'(irq), 32'h0);
    for (int c = 0; c < N; c++) begin
      rd(sts(c), d);
      check("R8 status", d, (c == 1) ? 32'h0001_0077 : (c == 2) ? 32'h0001_0042 : 32'h0);
    end
  endtask

  task automatic t_oor_slot();
    logic [31:0] d;
    wr(6'h20, 32'h4000_0005);
    wr(6'h38, 32'h4003_0006);
    check("R9 irq", 32'(irq), 32'h0);
    rd(sts(0), d); check("R9 status0", d, 32'h0);
    rd(sts(3), d); check("R9 status3", d, 32'h0);
    rd(6'h20, d); check("R9 read ctrl", d, 32'h0);
    rd(6'h24, d); check("R9 read status", d, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_plain_ctrl();
    t_generate();
    t_overwrite();
    t_status_write();
    t_ack();
    t_self();
    t_bad_dst();
    t_oor_slot();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule